// File: doc/BRIEF.md
# Configurable Registered Address Buffer

This block registers the command and address word that travels from a memory controller to the devices on a memory module. On each rising clock edge it captures the input word and drives it out one clock later. Two static strap inputs set its shape. With the fan-out strap low it is a 25-bit register with one output per input. With the fan-out strap high it is a 14-bit register in which every captured bit drives two outputs. In that mode the mapping strap picks which 14-bit slice of the input is carried.

Two active-low chip selects let the module save power while idle. When both are high at a clock edge, the outputs keep the word they already hold. The active-low reset clears the register on the clock edge. While it is held low, the outputs are also forced to zero at once. It outranks the chip-select hold. The straps are meant to be tied off. Behaviour after a strap change during operation is not defined.

Top module: `cfg_addr_regbuf`

## Requirements
- R1: With `cfg_fanout`=0, a clock edge at which either chip select is low loads `d_i[24:0]`, and `q_o[24:0]` shows that word from then on.
- R2: With `cfg_fanout`=0, the top outputs `q_o[27:25]` are always 0.
- R3: With `cfg_fanout`=1 and `cfg_map_b`=0, a loading edge places `d_i[13:0]` on both `q_o[13:0]` and `q_o[27:14]`. The bits `d_i[24:14]` have no effect.
- R4: With `cfg_fanout`=1 and `cfg_map_b`=1, a loading edge places `d_i[24:11]` on both `q_o[13:0]` and `q_o[27:14]`. The bits `d_i[10:0]` have no effect.
- R5: At a clock edge where `cs_a_n` and `cs_b_n` are both 1, `q_o` keeps its value, whatever `d_i` holds.
- R6: Either chip select alone being 0 is enough to load the word at that edge.
- R7: While `rst_n` is 0, `q_o` is all zero, with no clock edge needed. A clock edge with `rst_n`=0 clears the register even when both chip selects are 1.
- R8: After `rst_n` returns to 1, `q_o` stays zero until the first edge at which a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears state and forces outputs low |
| cfg_fanout | input | 1 | Strap: 0 = 25-bit one-to-one, 1 = 14-bit one-to-two |
| cfg_map_b | input | 1 | Strap in one-to-two mode: 0 = low input slice, 1 = high input slice |
| cs_a_n | input | 1 | Active-low chip select, first source |
| cs_b_n | input | 1 | Active-low chip select, second source |
| d_i | input | 25 | Command/address input word |
| q_o | output | 28 | Registered outputs |

## Verification
The hardest case to reach is a reset arriving while the outputs are frozen by the chip selects. The bench drives a live word with a chip select low and then raises both selects. It pulls reset low partway through a clock period and checks for zero before the next edge. It then releases reset with the selects still high, so the old word must not come back. The ignored input bits of each one-to-two mapping are toggled while the selected slice is held, so any leak of those bits shows at the outputs.

// File: rtl/cfg_addr_regbuf_pkg.sv
// Package: shared routing-mode type and strap decode for the address buffer.
// Assumes the straps are static; the decode is purely combinational.
package cfg_addr_regbuf_pkg;

    typedef enum logic [1:0] {
        ROUTE_WIDE  = 2'd0,
        ROUTE_LOW   = 2'd1,
        ROUTE_HIGH  = 2'd2
    } route_mode_e;

    // Turns the two straps into a routing mode.
    function automatic route_mode_e decode_straps(input logic fanout, input logic map_b);
        route_mode_e m;
        if (!fanout)
            m = ROUTE_WIDE;
        else if (map_b)
            m = ROUTE_HIGH;
        else
            m = ROUTE_LOW;
        return m;
    endfunction

endpackage

// File: rtl/cfg_addr_regbuf_route.sv
// Module: cfg_addr_regbuf_route
// Maps the raw input word onto the output positions for the chosen mode.
// Wide mode passes the input straight through and drives positions above
// WIDE_W low. Fan-out modes copy a NARROW_W slice (low or high end of the
// input) onto the primary lane group and its mirror group.
// Assumes NARROW_W <= WIDE_W <= 2*NARROW_W.
module cfg_addr_regbuf_route
    import cfg_addr_regbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14,
    localparam int OUT_W   = 2 * NARROW_W,
    localparam int HI_LSB  = WIDE_W - NARROW_W
) (
    input  route_mode_e        mode_i,
    input  logic [WIDE_W-1:0]  d_i,
    output logic [OUT_W-1:0]   routed_o
);

    logic [NARROW_W-1:0] slice_lo;
    logic [NARROW_W-1:0] slice_hi;

    assign slice_lo = d_i[NARROW_W-1:0];
    assign slice_hi = d_i[HI_LSB +: NARROW_W];

    for (genvar i = 0; i < OUT_W; i++) begin : g_lane
        localparam int LANE = i % NARROW_W;
        logic wide_bit;
        if (i < WIDE_W) begin : g_used
            assign wide_bit = d_i[i];
        end else begin : g_unused
            assign wide_bit = 1'b0;
        end
        // Selects the source of one output position.
        always_comb begin
            unique case (mode_i)
                ROUTE_LOW:  routed_o[i] = slice_lo[LANE];
                ROUTE_HIGH: routed_o[i] = slice_hi[LANE];
                default:    routed_o[i] = wide_bit;
            endcase
        end
    end

endmodule

// File: rtl/cfg_addr_regbuf_csgate.sv
// Module: cfg_addr_regbuf_csgate
// Builds the load enable from the two active-low chip selects: a load
// happens when at least one select is low at the clock edge.
// Assumes both selects are sampled on the same edge as the data.
module cfg_addr_regbuf_csgate (
    input  logic cs_a_n,
    input  logic cs_b_n,
    output logic load_o
);

    // Load unless both selects are idle (high).
    always_comb load_o = !(cs_a_n && cs_b_n);

endmodule

// File: rtl/cfg_addr_regbuf_outreg.sv
// Module: cfg_addr_regbuf_outreg
// Output register with hold and synchronous active-low reset. The outputs
// are also gated low combinationally while reset is held.
// Assumes rst_n is synchronous to clk at release.
module cfg_addr_regbuf_outreg #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q_r;

    // Clears on reset, loads when enabled, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_r <= '0;
        else if (load_i)
            q_r <= d_i;
    end

    // Forces the outputs low for as long as reset is held.
    always_comb q_o = rst_n ? q_r : '0;

endmodule

// File: rtl/cfg_addr_regbuf.sv
// Module: cfg_addr_regbuf (top)
// Strap-configured registered command/address buffer: 25-bit one-to-one
// or 14-bit one-to-two with a choice of input slice, output hold driven
// by two chip selects, and a reset that overrides the hold.
// Assumes cfg_fanout and cfg_map_b are tied off for the whole run.
module cfg_addr_regbuf
    import cfg_addr_regbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14,
    localparam int OUT_W   = 2 * NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fanout,
    input  logic              cfg_map_b,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic [WIDE_W-1:0] d_i,
    output logic [OUT_W-1:0]  q_o
);

    route_mode_e        mode;
    logic [OUT_W-1:0]   routed;
    logic               load;

    // Decodes the static straps into a routing mode.
    always_comb mode = decode_straps(cfg_fanout, cfg_map_b);

    cfg_addr_regbuf_route #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W)
    ) u_route (
        .mode_i   (mode),
        .d_i      (d_i),
        .routed_o (routed)
    );

    cfg_addr_regbuf_csgate u_csgate (
        .cs_a_n (cs_a_n),
        .cs_b_n (cs_b_n),
        .load_o (load)
    );

    cfg_addr_regbuf_outreg #(
        .W (OUT_W)
    ) u_outreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .d_i    (routed),
        .q_o    (q_o)
    );

endmodule

// File: rtl/cfg_addr_regbuf_chk.sv
// Module: cfg_addr_regbuf_chk
// Port-level properties of the address buffer, bound to the top module.
module cfg_addr_regbuf_chk #(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14,
    localparam int OUT_W   = 2 * NARROW_W,
    localparam int HI_LSB  = WIDE_W - NARROW_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_fanout,
    input logic              cfg_map_b,
    input logic              cs_a_n,
    input logic              cs_b_n,
    input logic [WIDE_W-1:0] d_i,
    input logic [OUT_W-1:0]  q_o
);

    // Outputs are zero whenever reset is held.
    always_comb begin
        if (!rst_n)
            AST_RESET_ZERO: assert (q_o == '0); // R7
    end

    AST_WIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fanout && !(cs_a_n && cs_b_n)) |=> q_o[WIDE_W-1:0] == $past(d_i)); // R1

    AST_WIDE_TOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fanout |-> q_o[OUT_W-1:WIDE_W] == '0); // R2

    AST_MAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fanout && !cfg_map_b && !(cs_a_n && cs_b_n))
        |=> (q_o[NARROW_W-1:0] == $past(d_i[NARROW_W-1:0]))
            && (q_o[OUT_W-1:NARROW_W] == $past(d_i[NARROW_W-1:0]))); // R3

    AST_MAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fanout && cfg_map_b && !(cs_a_n && cs_b_n))
        |=> (q_o[NARROW_W-1:0] == $past(d_i[HI_LSB +: NARROW_W]))
            && (q_o[OUT_W-1:NARROW_W] == $past(d_i[HI_LSB +: NARROW_W]))); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_a_n && cs_b_n) |=> $stable(q_o)); // R5

endmodule

bind cfg_addr_regbuf cfg_addr_regbuf_chk #(
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_fanout (cfg_fanout),
    .cfg_map_b  (cfg_map_b),
    .cs_a_n     (cs_a_n),
    .cs_b_n     (cs_b_n),
    .d_i        (d_i),
    .q_o        (q_o)
);

// File: tb/cfg_addr_regbuf_bench.sv
// Bench: behavioural reference model compared on every falling edge, plus
// directed checks for reset timing and ignored input bits.
module cfg_addr_regbuf_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fanout = 1'b0;
    logic        cfg_map_b = 1'b0;
    logic        cs_a_n = 1'b1;
    logic        cs_b_n = 1'b1;
    logic [24:0] d_i = '0;
    logic [27:0] q_o;

    int    tests = 0;
    int    fails = 0;
    bit    done = 0;
    bit    comparing = 0;
    string scen = "R7 reset";
    logic [27:0] model_q = '0;

    always #2 clk = ~clk;

    cfg_addr_regbuf u_cfg_addr_regbuf (
        .clk(clk), .rst_n(rst_n), .cfg_fanout(cfg_fanout), .cfg_map_b(cfg_map_b),
        .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .d_i(d_i), .q_o(q_o)
    );

    function automatic logic [27:0] expect_word(input logic [24:0] d, input logic fan, input logic mb);
        logic [13:0] s;
        if (!fan) return {3'b000, d};
        s = mb ? d[24:11] : d[13:0];
        return {s, s};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [27:0] act, input logic [27:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model: behaviour at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) model_q = '0;
        else if (!(cs_a_n && cs_b_n)) model_q = expect_word(d_i, cfg_fanout, cfg_map_b);
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (comparing) begin
            logic [27:0] e;
            e = rst_n ? model_q : 28'h0;
            check(q_o === e, scen, q_o, e);
        end
    end

    task automatic step(input logic [24:0] d, input logic a, input logic b, input string s);
        @(negedge clk);
        #1;
        d_i = d; cs_a_n = a; cs_b_n = b; scen = s;
    endtask

    task automatic straps(input logic fan, input logic mb);
        @(negedge clk); #1;
        rst_n = 1'b0; cfg_fanout = fan; cfg_map_b = mb; scen = "R7 reset for strap change";
        repeat (2) @(negedge clk);
        #1; rst_n = 1'b1;
    endtask

    initial begin
        logic [24:0] w;
        logic [27:0] held;
        repeat (3) @(negedge clk);
        comparing = 1;
        check(q_o === 28'h0, "R7 reset state", q_o, 28'h0);
        // Release with selects idle: outputs stay zero.
        @(negedge clk); #1; rst_n = 1'b1; scen = "R8 idle after release";
        repeat (3) @(negedge clk);
        check(q_o === 28'h0, "R8 zero until first load", q_o, 28'h0);

        // Wide mode.
        for (int i = 0; i < 40; i++) step(25'($urandom), 1'b0, 1'($urandom), "R1 wide load / R2 top low");
        for (int i = 0; i < 20; i++) step(25'($urandom), 1'b1, 1'b0, "R6 second select alone");
        step(25'h1ABCDEF, 1'b0, 1'b1, "R6 first select alone");
        @(negedge clk);
        check(q_o === 28'h1ABCDEF, "R6 first select alone", q_o, 28'h1ABCDEF);
        held = q_o;
        for (int i = 0; i < 15; i++) step(25'($urandom), 1'b1, 1'b1, "R5 hold");
        @(negedge clk);
        check(q_o === held, "R5 hold keeps word", q_o, held);
        check(q_o[27:25] === 3'b000, "R2 top positions low", {25'h0, q_o[27:25]}, 28'h0);

        // Reset during hold: immediate zero, no edge needed.
        @(negedge clk); #1; rst_n = 1'b0; scen = "R7 reset over hold";
        #1;
        check(q_o === 28'h0, "R7 immediate force low", q_o, 28'h0);
        repeat (2) @(negedge clk);
        #1; rst_n = 1'b1; scen = "R8 hold after reset";
        repeat (4) @(negedge clk);
        check(q_o === 28'h0, "R8 old word not restored", q_o, 28'h0);

        // Fan-out, low slice.
        straps(1'b1, 1'b0);
        for (int i = 0; i < 40; i++) step(25'($urandom), 1'($urandom), 1'b0, "R3 low slice mirrored");
        w = 25'($urandom);
        for (int i = 0; i < 10; i++) step({11'($urandom), w[13:0]}, 1'b0, 1'b0, "R3 upper bits ignored");
        @(negedge clk);
        check(q_o === {w[13:0], w[13:0]}, "R3 upper bits ignored", q_o, {w[13:0], w[13:0]});
        for (int i = 0; i < 10; i++) step(25'($urandom), 1'b1, 1'b1, "R5 hold fan-out");

        // Fan-out, high slice.
        straps(1'b1, 1'b1);
        for (int i = 0; i < 40; i++) step(25'($urandom), 1'b0, 1'($urandom), "R4 high slice mirrored");
        w = 25'($urandom);
        for (int i = 0; i < 10; i++) step({w[24:11], 11'($urandom)}, 1'b1, 1'b0, "R4 lower bits ignored");
        @(negedge clk);
        check(q_o === {w[24:11], w[24:11]}, "R4 lower bits ignored", q_o, {w[24:11], w[24:11]});
        held = q_o;
        for (int i = 0; i < 10; i++) step(25'($urandom), 1'b1, 1'b1, "R5 hold high slice");
        @(negedge clk);
        check(q_o === held, "R5 hold high slice", q_o, held);

        // Back to wide: top positions low again.
        straps(1'b0, 1'b1);
        for (int i = 0; i < 20; i++) step(25'($urandom), 1'b0, 1'b0, "R1 wide after fan-out / R2");
        @(negedge clk);
        check(q_o[27:25] === 3'b000, "R2 top positions low after mode change", {25'h0, q_o[27:25]}, 28'h0);

        comparing = 0;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule